// File: doc/BRIEF.md
# Quadrature Position Decoder

This block turns two phase inputs from an incremental encoder, plus a home marker and a once-per-turn index marker, into a 32-bit position count, a 16-bit turn count and a 16-bit signed difference count. The phase, home and index inputs are expected to be synchronized and debounced already. The block decodes either a true two-phase quadrature signal or a single-phase pulse stream with a separate direction line. It can reverse the sense of motion, keep the position inside a programmable window, flag a programmable compare match, and detect loss of motion with a cycle-count watchdog.

Software reaches the block through a small 16-bit word-addressed register bus with registered read data. Any read of a live counter copies all three counters into hold registers on the same clock edge, so a 32-bit position and its matching turn and difference values can be read over several bus cycles without tearing. Events raise sticky flags that are cleared by writing ones. One interrupt line combines every flag with its enable.

Top module: `qdec_top`

## Requirements
- R1: In quadrature mode, with {A,B} stepping 00, 10, 11, 01 and back to 00 (A leads), each single-phase change moves the position by +1; the opposite order moves it by -1.
- R2: When A and B both change in one cycle in quadrature mode the position is unchanged and flag bit 4 (address 1) is set.
- R3: With configuration bit 0 (address 0) set, every count moves in the opposite direction.
- R4: With configuration bit 1 set, only rising edges of A count, up when B is 0 and down when B is 1.
- R5: Writing 1 to configuration bit 15 copies the initial value (high half at address 4, low half at address 5) into the position in that cycle; bit 15 always reads back 0.
- R6: Without configuration bit 9 the position wraps across 32 bits; with it set the position wraps from the modulus (high address 6, low address 7) to the initial value going up and from the initial value to the modulus going down. An upward wrap sets flag bit 5, a downward wrap sets flag bit 6.
- R7: The turn count (address 12) steps on each index event, up or down by the last count direction, or, with configuration bit 8 set, steps +1 on every upward wrap and -1 on every downward wrap.
- R8: Home is armed by configuration bit 2 and index by bit 4; bits 3 and 5 select the falling edge instead of the rising edge. A home event sets flag bit 0 and reloads the initial value; an index event sets flag bit 1 and reloads only when configuration bit 10 is set. A disarmed input has no effect.
- R9: A read of address 10 (position high), 12 (turn) or 13 (difference) returns the live value and copies position, turn and difference into holds (addresses 14/15, 16, 17) and clears the difference count; address 11 returns the low half of the held position.
- R10: The compare value (addresses 8 and 9) resets to 0xFFFFFFFF. Flag bit 3 sets while the position equals it, or, with configuration bit 7, on every counter read of R9.
- R11: With configuration bit 6 set, flag bit 2 sets when no phase change has occurred for more than the count at address 3 cycles.
- R12: Writing 1 to a flag bit (bits 0 to 6 at address 1) clears it, writing 0 leaves it; bit 8 reads the last count direction (1 = up) and ignores writes.
- R13: The interrupt output is high exactly when some flag is set whose enable bit at address 2 (same bit position) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pha_i | input | 1 | Phase A, synchronized |
| phb_i | input | 1 | Phase B, synchronized |
| home_i | input | 1 | Home marker, synchronized |
| index_i | input | 1 | Index marker, synchronized |
| bus_addr_i | input | 5 | Register word address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Combined interrupt |

## Verification
The decoder is driven with forward and backward Gray sequences, with a two-bit jump that must not count, with the reverse bit set, and with a single-phase pulse train whose direction line flips, so that a sign error, a missed edge or a double count in any one of those paths shows up as a distinct wrong position. Wrapping is tried at both ends of the 32-bit range and at both ends of a small modulus window, which separates the rollover and rollunder flags and the turn-count source. Snapshot reads are interleaved with motion so that stale or torn hold values, and a difference count that fails to clear, are seen.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
    localparam int unsigned ADDR_W = 5;

    // register word addresses
    localparam logic [ADDR_W-1:0] RA_CFG     = 5'd0;
    localparam logic [ADDR_W-1:0] RA_FLAGS   = 5'd1;
    localparam logic [ADDR_W-1:0] RA_IEN     = 5'd2;
    localparam logic [ADDR_W-1:0] RA_WDT     = 5'd3;
    localparam logic [ADDR_W-1:0] RA_INIT_HI = 5'd4;
    localparam logic [ADDR_W-1:0] RA_INIT_LO = 5'd5;
    localparam logic [ADDR_W-1:0] RA_MOD_HI  = 5'd6;
    localparam logic [ADDR_W-1:0] RA_MOD_LO  = 5'd7;
    localparam logic [ADDR_W-1:0] RA_CMP_HI  = 5'd8;
    localparam logic [ADDR_W-1:0] RA_CMP_LO  = 5'd9;
    localparam logic [ADDR_W-1:0] RA_POS_HI  = 5'd10;
    localparam logic [ADDR_W-1:0] RA_POS_LO  = 5'd11;
    localparam logic [ADDR_W-1:0] RA_REV     = 5'd12;
    localparam logic [ADDR_W-1:0] RA_DIFF    = 5'd13;
    localparam logic [ADDR_W-1:0] RA_HPOS_HI = 5'd14;
    localparam logic [ADDR_W-1:0] RA_HPOS_LO = 5'd15;
    localparam logic [ADDR_W-1:0] RA_HREV    = 5'd16;
    localparam logic [ADDR_W-1:0] RA_HDIFF   = 5'd17;

    // configuration bit positions
    localparam int unsigned CB_REVERSE   = 0;
    localparam int unsigned CB_SINGLE    = 1;
    localparam int unsigned CB_HOME_EN   = 2;
    localparam int unsigned CB_HOME_FALL = 3;
    localparam int unsigned CB_IDX_EN    = 4;
    localparam int unsigned CB_IDX_FALL  = 5;
    localparam int unsigned CB_WDOG_EN   = 6;
    localparam int unsigned CB_CMP_READ  = 7;
    localparam int unsigned CB_REV_MOD   = 8;
    localparam int unsigned CB_MOD_EN    = 9;
    localparam int unsigned CB_IDX_LOAD  = 10;
    localparam int unsigned CFG_W        = 11;
    localparam int unsigned CB_SW_LOAD   = 15;

    // flag bit positions
    localparam int unsigned FL_HOME  = 0;
    localparam int unsigned FL_INDEX = 1;
    localparam int unsigned FL_WDOG  = 2;
    localparam int unsigned FL_CMP   = 3;
    localparam int unsigned FL_BOTH  = 4;
    localparam int unsigned FL_OVER  = 5;
    localparam int unsigned FL_UNDER = 6;
    localparam int unsigned FLAG_N   = 7;
    localparam int unsigned DIR_BIT  = 8;
endpackage

// File: rtl/qdec_phase_det.sv
module qdec_phase_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pha_i,
    input  logic phb_i,
    input  logic reverse_i,
    input  logic single_i,
    output logic step_up_o,
    output logic step_dn_o,
    output logic both_o,
    output logic moved_o
);
    typedef struct packed {
        logic a;
        logic b;
    } ph_t;

    ph_t ph_d, ph_q;
    logic chg_a, chg_b, count, up_raw, up;

    always_comb begin
        ph_d.a  = pha_i;
        ph_d.b  = phb_i;
        chg_a   = pha_i ^ ph_q.a;
        chg_b   = phb_i ^ ph_q.b;
        moved_o = chg_a | chg_b;
        if (single_i) begin
            count  = pha_i & ~ph_q.a;
            up_raw = ~phb_i;
            both_o = 1'b0;
        end else begin
            count  = chg_a ^ chg_b;
            up_raw = ~(ph_q.a ^ phb_i);
            both_o = chg_a & chg_b;
        end
        up        = up_raw ^ reverse_i;
        step_up_o = count & up;
        step_dn_o = count & ~up;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end
endmodule

// File: rtl/qdec_edge_trig.sv
module qdec_edge_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    input  logic en_i,
    input  logic fall_i,
    output logic evt_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
        if (!en_i)       evt_o = 1'b0;
        else if (fall_i) evt_o = prev_q & ~sig_i;
        else             evt_o = ~prev_q & sig_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/qdec_wdog.sv
module qdec_wdog #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             moved_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             timeout_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        timeout_o = 1'b0;
        if (!en_i || moved_i) begin
            cnt_d = '0;
        end else if (cnt_q == limit_i) begin
            timeout_o = 1'b1;
            cnt_d     = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/qdec_pos_core.sv
module qdec_pos_core #(
    parameter int unsigned POS_W  = 32,
    parameter int unsigned REV_W  = 16,
    parameter int unsigned DIFF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_up_i,
    input  logic              step_dn_i,
    input  logic              load_i,
    input  logic              index_i,
    input  logic              mod_en_i,
    input  logic              rev_on_mod_i,
    input  logic              snap_i,
    input  logic [POS_W-1:0]  init_i,
    input  logic [POS_W-1:0]  mod_i,
    output logic [POS_W-1:0]  pos_o,
    output logic [REV_W-1:0]  rev_o,
    output logic [DIFF_W-1:0] diff_o,
    output logic [POS_W-1:0]  hpos_o,
    output logic [REV_W-1:0]  hrev_o,
    output logic [DIFF_W-1:0] hdiff_o,
    output logic              over_o,
    output logic              under_o,
    output logic              dir_o
);
    typedef struct packed {
        logic [POS_W-1:0]  pos;
        logic [REV_W-1:0]  rev;
        logic [DIFF_W-1:0] diff;
        logic [POS_W-1:0]  hpos;
        logic [REV_W-1:0]  hrev;
        logic [DIFF_W-1:0] hdiff;
        logic              dir;
    } core_t;

    core_t d, q;

    always_comb begin
        d       = q;
        over_o  = 1'b0;
        under_o = 1'b0;

        if (snap_i) begin
            d.hpos  = q.pos;
            d.hrev  = q.rev;
            d.hdiff = q.diff;
            d.diff  = '0;
        end

        if (step_up_i) begin
            d.dir  = 1'b1;
            d.diff = d.diff + 1'b1;
            if (mod_en_i && (q.pos == mod_i)) begin
                d.pos  = init_i;
                over_o = 1'b1;
            end else begin
                d.pos  = q.pos + 1'b1;
                over_o = !mod_en_i && (&q.pos);
            end
        end else if (step_dn_i) begin
            d.dir  = 1'b0;
            d.diff = d.diff - 1'b1;
            if (mod_en_i && (q.pos == init_i)) begin
                d.pos   = mod_i;
                under_o = 1'b1;
            end else begin
                d.pos   = q.pos - 1'b1;
                under_o = !mod_en_i && (q.pos == '0);
            end
        end

        if (load_i) begin
            d.pos   = init_i;
            over_o  = 1'b0;
            under_o = 1'b0;
        end

        if (rev_on_mod_i) begin
            if (over_o)       d.rev = q.rev + 1'b1;
            else if (under_o) d.rev = q.rev - 1'b1;
        end else if (index_i) begin
            d.rev = d.dir ? q.rev + 1'b1 : q.rev - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pos_o   = q.pos;
    assign rev_o   = q.rev;
    assign diff_o  = q.diff;
    assign hpos_o  = q.hpos;
    assign hrev_o  = q.hrev;
    assign hdiff_o = q.hdiff;
    assign dir_o   = q.dir;
endmodule

// File: rtl/qdec_top.sv
module qdec_top
    import qdec_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pha_i,
    input  logic              phb_i,
    input  logic              home_i,
    input  logic              index_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    localparam int unsigned POS_W = 2 * DATA_W;
    localparam int unsigned REV_W = DATA_W;

    typedef struct packed {
        logic [CFG_W-1:0]  cfg;
        logic [FLAG_N-1:0] ien;
        logic [FLAG_N-1:0] flags;
        logic [DATA_W-1:0] wdt;
        logic [POS_W-1:0]  init;
        logic [POS_W-1:0]  modv;
        logic [POS_W-1:0]  cmp;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t d, q;

    logic step_up, step_dn, both_chg, moved;
    logic home_evt, idx_evt, wd_timeout;
    logic over, under, dir_val;
    logic sw_load, reload, snap, mod_en;
    logic [POS_W-1:0]  pos_val, hold_pos;
    logic [REV_W-1:0]  rev_val, hold_rev;
    logic [DATA_W-1:0] diff_val, hold_diff;
    logic [FLAG_N-1:0] set_vec, clr_vec, flag_vec;

    qdec_phase_det u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .pha_i     (pha_i),
        .phb_i     (phb_i),
        .reverse_i (q.cfg[CB_REVERSE]),
        .single_i  (q.cfg[CB_SINGLE]),
        .step_up_o (step_up),
        .step_dn_o (step_dn),
        .both_o    (both_chg),
        .moved_o   (moved)
    );

    qdec_edge_trig u_home (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (home_i),
        .en_i   (q.cfg[CB_HOME_EN]),
        .fall_i (q.cfg[CB_HOME_FALL]),
        .evt_o  (home_evt)
    );

    qdec_edge_trig u_index (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (index_i),
        .en_i   (q.cfg[CB_IDX_EN]),
        .fall_i (q.cfg[CB_IDX_FALL]),
        .evt_o  (idx_evt)
    );

    qdec_wdog #(.CNT_W(DATA_W)) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (q.cfg[CB_WDOG_EN]),
        .moved_i   (moved),
        .limit_i   (q.wdt),
        .timeout_o (wd_timeout)
    );

    assign sw_load = bus_wr_i && (bus_addr_i == RA_CFG) && bus_wdata_i[CB_SW_LOAD];
    assign reload  = sw_load || home_evt || (idx_evt && q.cfg[CB_IDX_LOAD]);
    assign snap    = bus_rd_i && ((bus_addr_i == RA_POS_HI) || (bus_addr_i == RA_REV) ||
                                  (bus_addr_i == RA_DIFF));
    assign mod_en  = q.cfg[CB_MOD_EN];

    qdec_pos_core #(.POS_W(POS_W), .REV_W(REV_W), .DIFF_W(DATA_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_up_i    (step_up),
        .step_dn_i    (step_dn),
        .load_i       (reload),
        .index_i      (idx_evt),
        .mod_en_i     (mod_en),
        .rev_on_mod_i (q.cfg[CB_REV_MOD]),
        .snap_i       (snap),
        .init_i       (q.init),
        .mod_i        (q.modv),
        .pos_o        (pos_val),
        .rev_o        (rev_val),
        .diff_o       (diff_val),
        .hpos_o       (hold_pos),
        .hrev_o       (hold_rev),
        .hdiff_o      (hold_diff),
        .over_o       (over),
        .under_o      (under),
        .dir_o        (dir_val)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[FL_HOME]  = home_evt;
        set_vec[FL_INDEX] = idx_evt;
        set_vec[FL_WDOG]  = wd_timeout;
        set_vec[FL_CMP]   = q.cfg[CB_CMP_READ] ? snap : (pos_val == q.cmp);
        set_vec[FL_BOTH]  = both_chg;
        set_vec[FL_OVER]  = over;
        set_vec[FL_UNDER] = under;
        clr_vec = (bus_wr_i && (bus_addr_i == RA_FLAGS)) ? bus_wdata_i[FLAG_N-1:0] : '0;
    end

    always_comb begin
        d = q;
        if (bus_wr_i) begin
            case (bus_addr_i)
                RA_CFG:     d.cfg                = bus_wdata_i[CFG_W-1:0];
                RA_IEN:     d.ien                = bus_wdata_i[FLAG_N-1:0];
                RA_WDT:     d.wdt                = bus_wdata_i;
                RA_INIT_HI: d.init[POS_W-1:DATA_W] = bus_wdata_i;
                RA_INIT_LO: d.init[DATA_W-1:0]     = bus_wdata_i;
                RA_MOD_HI:  d.modv[POS_W-1:DATA_W] = bus_wdata_i;
                RA_MOD_LO:  d.modv[DATA_W-1:0]     = bus_wdata_i;
                RA_CMP_HI:  d.cmp[POS_W-1:DATA_W]  = bus_wdata_i;
                RA_CMP_LO:  d.cmp[DATA_W-1:0]      = bus_wdata_i;
                default: ;
            endcase
        end
        // a new event wins over a clear in the same cycle
        d.flags = (q.flags & ~clr_vec) | set_vec;

        if (bus_rd_i) begin
            d.rdata = '0;
            case (bus_addr_i)
                RA_CFG:     d.rdata[CFG_W-1:0]  = q.cfg;
                RA_FLAGS: begin
                    d.rdata[FLAG_N-1:0] = q.flags;
                    d.rdata[DIR_BIT]    = dir_val;
                end
                RA_IEN:     d.rdata[FLAG_N-1:0] = q.ien;
                RA_WDT:     d.rdata = q.wdt;
                RA_INIT_HI: d.rdata = q.init[POS_W-1:DATA_W];
                RA_INIT_LO: d.rdata = q.init[DATA_W-1:0];
                RA_MOD_HI:  d.rdata = q.modv[POS_W-1:DATA_W];
                RA_MOD_LO:  d.rdata = q.modv[DATA_W-1:0];
                RA_CMP_HI:  d.rdata = q.cmp[POS_W-1:DATA_W];
                RA_CMP_LO:  d.rdata = q.cmp[DATA_W-1:0];
                RA_POS_HI:  d.rdata = pos_val[POS_W-1:DATA_W];
                RA_POS_LO:  d.rdata = hold_pos[DATA_W-1:0];
                RA_REV:     d.rdata = rev_val;
                RA_DIFF:    d.rdata = diff_val;
                RA_HPOS_HI: d.rdata = hold_pos[POS_W-1:DATA_W];
                RA_HPOS_LO: d.rdata = hold_pos[DATA_W-1:0];
                RA_HREV:    d.rdata = hold_rev;
                RA_HDIFF:   d.rdata = hold_diff;
                default:    d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cmp  <= '1;
        end else begin
            q <= d;
        end
    end

    assign flag_vec    = q.flags;
    assign bus_rdata_o = q.rdata;
    assign irq_o       = |(q.flags & q.ien);
endmodule

// File: rtl/qdec_checker.sv
module qdec_checker #(
    parameter int unsigned POS_W  = 32,
    parameter int unsigned FL_W   = 7,
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_up,
    input logic              step_dn,
    input logic              both_chg,
    input logic              reload,
    input logic              mod_en,
    input logic              snap,
    input logic              dir_val,
    input logic [POS_W-1:0]  pos_val,
    input logic [POS_W-1:0]  hold_pos,
    input logic [FL_W-1:0]   flag_vec,
    input logic              bus_wr,
    input logic [4:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata
);
    // R1: a step is never both up and down
    a_r1_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up && step_dn));

    // R1: an up step without reload or window advances the position by one
    a_r1_up_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && !reload && !mod_en) |=> (pos_val == $past(pos_val) + 1'b1));

    // R2: simultaneous change of both phases leaves the position alone
    a_r2_both_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (both_chg && !reload) |=> (pos_val == $past(pos_val)));

    // R9: a counter read captures the position of that cycle
    a_r9_hold_capture: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (hold_pos == $past(pos_val)));

    // R12: direction bit follows an up count
    a_r12_dir_up: assert property (@(posedge clk) disable iff (!rst_n)
        step_up |=> dir_val);

    // R12: writing 0 to a set flag keeps it set
    a_r12_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 5'd1 && flag_vec[4] && !bus_wdata[4]) |=> flag_vec[4]);

    // R1: no count when both step outputs are idle and no reload
    a_r1_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_up && !step_dn && !reload) |=> $stable(pos_val));
endmodule

bind qdec_top qdec_checker #(.POS_W(2 * DATA_W), .FL_W(qdec_pkg::FLAG_N), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_up   (step_up),
    .step_dn   (step_dn),
    .both_chg  (both_chg),
    .reload    (reload),
    .mod_en    (mod_en),
    .snap      (snap),
    .dir_val   (dir_val),
    .pos_val   (pos_val),
    .hold_pos  (hold_pos),
    .flag_vec  (flag_vec),
    .bus_wr    (bus_wr_i),
    .bus_addr  (bus_addr_i),
    .bus_wdata (bus_wdata_i)
);

// File: tb/qdec_top_tb_top.sv
`timescale 1ns/1ps
module qdec_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pha = 1'b0, phb = 1'b0, home = 1'b0, index = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    int ph_idx = 0;

    always #2 clk = ~clk;

    qdec_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pha_i       (pha),
        .phb_i       (phb),
        .home_i      (home),
        .index_i     (index),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [15:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        v = rdata;
    endtask

    task automatic read_pos(output logic [31:0] p);
        logic [15:0] hi, lo;
        bus_read(5'd10, hi);
        bus_read(5'd11, lo);
        p = {hi, lo};
    endtask

    task automatic apply_pins();
        case (ph_idx)
            0: {pha, phb} = 2'b00;
            1: {pha, phb} = 2'b10;
            2: {pha, phb} = 2'b11;
            default: {pha, phb} = 2'b01;
        endcase
    endtask

    task automatic quad(input bit fwd, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ph_idx = fwd ? (ph_idx + 1) % 4 : (ph_idx + 3) % 4;
            apply_pins();
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] p; logic [15:0] v;
        read_pos(p);            chk("R9 reset position", p, 32'h0);
        bus_read(5'd1, v);      chk("R12 reset flags", {16'h0, v}, 32'h0);
        bus_read(5'd8, v);      chk("R10 compare high reset", {16'h0, v}, 32'h0000FFFF);
        bus_read(5'd9, v);      chk("R10 compare low reset", {16'h0, v}, 32'h0000FFFF);
        chk("R13 reset irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_quad();
        logic [31:0] p; logic [15:0] v;
        quad(1'b1, 10);
        read_pos(p);            chk("R1 forward ten", p, 32'd10);
        bus_read(5'd1, v);      chk("R12 dir up", {31'h0, v[8]}, 32'h1);
        quad(1'b0, 3);
        read_pos(p);            chk("R1 backward three", p, 32'd7);
        bus_read(5'd1, v);      chk("R12 dir down", {31'h0, v[8]}, 32'h0);
        bus_write(5'd1, 16'h0100);
        bus_read(5'd1, v);      chk("R12 dir ignores write", {31'h0, v[8]}, 32'h0);
    endtask

    task automatic t_double();
        logic [31:0] p; logic [15:0] v;
        @(negedge clk);
        ph_idx = (ph_idx + 2) % 4;
        apply_pins();
        idle(2);
        read_pos(p);            chk("R2 jump no count", p, 32'd7);
        bus_read(5'd1, v);      chk("R2 both flag", {31'h0, v[4]}, 32'h1);
        bus_write(5'd1, 16'h0000);
        bus_read(5'd1, v);      chk("R12 zero write keeps", {31'h0, v[4]}, 32'h1);
        bus_write(5'd1, 16'h0010);
        bus_read(5'd1, v);      chk("R12 one write clears", {31'h0, v[4]}, 32'h0);
    endtask

    task automatic t_reverse();
        logic [31:0] p;
        bus_write(5'd0, 16'h0001);
        quad(1'b1, 4);
        read_pos(p);            chk("R3 reversed forward", p, 32'd3);
        bus_write(5'd0, 16'h0000);
    endtask

    task automatic t_single();
        logic [31:0] p;
        bus_write(5'd0, 16'h0002);
        @(negedge clk); pha = 1'b0; phb = 1'b0;
        idle(1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); pha = 1'b1;
            @(negedge clk); pha = 1'b0;
        end
        @(negedge clk); phb = 1'b1;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); pha = 1'b1;
            @(negedge clk); pha = 1'b0;
        end
        idle(1);
        read_pos(p);            chk("R4 single phase net", p, 32'd4);
        bus_write(5'd0, 16'h0000);
        @(negedge clk); phb = 1'b0;
        ph_idx = 0;
        idle(1);
    endtask

    task automatic t_swload();
        logic [31:0] p; logic [15:0] v;
        bus_write(5'd4, 16'h0001);
        bus_write(5'd5, 16'h0002);
        bus_write(5'd0, 16'h8000);
        read_pos(p);            chk("R5 software load", p, 32'h00010002);
        bus_read(5'd0, v);      chk("R5 command reads zero", {16'h0, v}, 32'h0);
    endtask

    task automatic t_wrap();
        logic [31:0] p; logic [15:0] v;
        bus_write(5'd4, 16'h0000);
        bus_write(5'd5, 16'h0000);
        bus_write(5'd0, 16'h8000);
        quad(1'b0, 1);
        read_pos(p);            chk("R6 wrap below zero", p, 32'hFFFFFFFF);
        bus_read(5'd1, v);      chk("R6 rollunder flag", {31'h0, v[6]}, 32'h1);
        quad(1'b1, 1);
        read_pos(p);            chk("R6 wrap above max", p, 32'h0);
        bus_read(5'd1, v);      chk("R6 rollover flag", {31'h0, v[5]}, 32'h1);
        bus_write(5'd1, 16'h007F);
    endtask

    task automatic t_mod();
        logic [31:0] p; logic [15:0] v;
        bus_write(5'd4, 16'h0000);
        bus_write(5'd5, 16'd5);
        bus_write(5'd6, 16'h0000);
        bus_write(5'd7, 16'd8);
        bus_write(5'd0, 16'h8300);
        quad(1'b1, 3);
        read_pos(p);            chk("R6 window top", p, 32'd8);
        bus_read(5'd12, v);     chk("R7 turns before wrap", {16'h0, v}, 32'd0);
        quad(1'b1, 1);
        read_pos(p);            chk("R6 window up wrap", p, 32'd5);
        bus_read(5'd1, v);      chk("R6 window rollover", {31'h0, v[5]}, 32'h1);
        bus_read(5'd12, v);     chk("R7 turn on rollover", {16'h0, v}, 32'd1);
        quad(1'b0, 1);
        read_pos(p);            chk("R6 window down wrap", p, 32'd8);
        bus_read(5'd1, v);      chk("R6 window rollunder", {31'h0, v[6]}, 32'h1);
        bus_read(5'd12, v);     chk("R7 turn on rollunder", {16'h0, v}, 32'd0);
        bus_write(5'd0, 16'h0000);
        bus_write(5'd1, 16'h007F);
    endtask

    task automatic t_trig();
        logic [31:0] p; logic [15:0] v;
        bus_write(5'd5, 16'd100);
        bus_write(5'd0, 16'h0410);
        quad(1'b1, 2);
        @(negedge clk); index = 1'b1;
        @(negedge clk); index = 1'b0;
        idle(1);
        read_pos(p);            chk("R8 index reload", p, 32'd100);
        bus_read(5'd12, v);     chk("R7 index turn up", {16'h0, v}, 32'd1);
        bus_read(5'd1, v);      chk("R8 index flag", {31'h0, v[1]}, 32'h1);
        @(negedge clk); home = 1'b1;
        @(negedge clk); home = 1'b0;
        idle(1);
        bus_read(5'd1, v);      chk("R8 home disarmed", {31'h0, v[0]}, 32'h0);
        bus_write(5'd0, 16'h041C);
        @(negedge clk); home = 1'b1;
        idle(1);
        bus_read(5'd1, v);      chk("R8 home rise ignored", {31'h0, v[0]}, 32'h0);
        quad(1'b1, 1);
        @(negedge clk); home = 1'b0;
        idle(1);
        read_pos(p);            chk("R8 home fall reload", p, 32'd100);
        bus_read(5'd1, v);      chk("R8 home flag", {31'h0, v[0]}, 32'h1);
        bus_write(5'd0, 16'h0000);
        bus_write(5'd1, 16'h007F);
    endtask

    task automatic t_snap();
        logic [15:0] v;
        bus_read(5'd12, v);     chk("R9 live turn", {16'h0, v}, 32'd1);
        bus_read(5'd14, v);     chk("R9 hold high", {16'h0, v}, 32'd0);
        bus_read(5'd15, v);     chk("R9 hold low", {16'h0, v}, 32'd100);
        bus_read(5'd16, v);     chk("R9 hold turn", {16'h0, v}, 32'd1);
        quad(1'b1, 5);
        bus_read(5'd15, v);     chk("R9 hold stays", {16'h0, v}, 32'd100);
        bus_read(5'd13, v);     chk("R9 live diff", {16'h0, v}, 32'd5);
        bus_read(5'd17, v);     chk("R9 hold diff", {16'h0, v}, 32'd5);
        bus_read(5'd13, v);     chk("R9 diff cleared", {16'h0, v}, 32'd0);
    endtask

    task automatic t_cmp();
        logic [15:0] v;
        bus_write(5'd8, 16'h0000);
        bus_write(5'd9, 16'd107);
        quad(1'b1, 1);
        bus_read(5'd1, v);      chk("R10 no match yet", {31'h0, v[3]}, 32'h0);
        quad(1'b1, 1);
        bus_read(5'd1, v);      chk("R10 equal match", {31'h0, v[3]}, 32'h1);
        quad(1'b1, 1);
        bus_write(5'd1, 16'h0008);
        bus_read(5'd1, v);      chk("R10 cleared past", {31'h0, v[3]}, 32'h0);
        bus_write(5'd0, 16'h0080);
        bus_read(5'd10, v);
        bus_read(5'd1, v);      chk("R10 read mode", {31'h0, v[3]}, 32'h1);
        bus_write(5'd0, 16'h0000);
        bus_write(5'd1, 16'h007F);
    endtask

    task automatic t_wdog();
        logic [15:0] v;
        bus_write(5'd3, 16'd20);
        bus_write(5'd0, 16'h0040);
        quad(1'b1, 1);
        idle(6);
        bus_read(5'd1, v);      chk("R11 before limit", {31'h0, v[2]}, 32'h0);
        idle(30);
        bus_read(5'd1, v);      chk("R11 timeout", {31'h0, v[2]}, 32'h1);
        bus_write(5'd0, 16'h0000);
        bus_write(5'd1, 16'h007F);
        bus_read(5'd1, v);      chk("R12 all cleared", {16'h0, v & 16'h007F}, 32'h0);
    endtask

    task automatic t_irq();
        bus_write(5'd2, 16'h0010);
        idle(1);
        chk("R13 enabled idle", {31'h0, irq}, 32'h0);
        @(negedge clk);
        ph_idx = (ph_idx + 2) % 4;
        apply_pins();
        idle(2);
        chk("R13 raised", {31'h0, irq}, 32'h1);
        bus_write(5'd2, 16'h0000);
        idle(1);
        chk("R13 masked", {31'h0, irq}, 32'h0);
        bus_write(5'd2, 16'h0010);
        bus_write(5'd1, 16'h0010);
        idle(1);
        chk("R13 cleared", {31'h0, irq}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_quad();
        t_double();
        t_reverse();
        t_single();
        t_swload();
        t_wrap();
        t_mod();
        t_trig();
        t_snap();
        t_cmp();
        t_wdog();
        t_irq();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule